// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block sits between a register bus and a serial audio engine. It buffers outgoing words in a 128-entry transmit queue and incoming words in a 64-entry receive queue. Software writes playback words through a data register, and the serializer drains them with a one-cycle pop strobe. The serializer deposits captured words with a push strobe, and software drains them by reading a data register.

Software paces itself through three sticky status flags. The transmit-space flag is raised whenever the free-entry count is at least a programmed 7-bit level. The underrun flag is raised when the serializer pops an empty transmit queue. The data-available flag is raised while the receive queue holds anything. A flag is cleared by writing a one to it, and a per-flag enable gates it onto a single interrupt line. Flush bits empty each queue. Two sample counters, which software can reload, count the words that were actually delivered and accepted.

Register map (word index on `reg_addr`): 0 control, 1 interrupt status, 2 interrupt enable, 3 level status, 4 transmit data, 5 receive data, 6 transmit sample count, 7 receive sample count. Read data is registered: it appears on `reg_rdata` on the clock edge that samples `reg_rd`.

Top module: `snd_fifo_pair`

## Requirements
- R1: After reset, the level status word reads 0x0080_0000. In the interrupt status, bit 4 reads 1 and all other bits read 0, because the default level is 0. `irq` is 0.
- R2: Each write to index 4 appends `reg_wdata` to the transmit queue. `tx_word` shows the oldest entry, and `tx_pop` removes it. Level status bits 23:16 give 128 minus the number of stored words.
- R3: Control bit 0 flushes the transmit queue and control bit 1 flushes the receive queue. After such a bit is set and then cleared, the queue holds no words. Control bits 14:8 (the level) read back as written.
- R4: Writing 1 to an interrupt status bit (0, 4 or 6) clears it, and writing 0 leaves it unchanged. If the bit's raising condition holds in the same cycle, the bit stays 1.
- R5: `irq` is 1 exactly when some status bit and the enable bit at the same position (index 2: bit 0, 4 or 6) are both 1.
- R6: A write to index 4 while 128 words are stored is dropped. The stored words and their order are unchanged.
- R7: Status bit 4 is raised in any cycle in which the transmit free count is greater than or equal to control bits 14:8.
- R8: A `tx_pop` while the transmit queue is empty raises status bit 6. While the queue is empty, `tx_word` is 0.
- R9: `rx_push` appends `rx_word`. A read of index 5 returns the oldest word and removes it. A read of index 5 on an empty queue returns 0 and changes nothing. Status bit 0 is raised while the queue is not empty.
- R10: Level status bits 5:0 give the stored receive count, held at 63 when 64 words are stored. An `rx_push` to a full receive queue is dropped.
- R11: Index 6 counts the words delivered by `tx_pop` and index 7 counts the words accepted by `rx_push`. A write to either index loads `reg_wdata` into that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tx_pop | input | 1 | Serializer takes the oldest transmit word |
| tx_word | output | 32 | Oldest transmit word, 0 when empty |
| rx_push | input | 1 | Serializer delivers a received word |
| rx_word | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
A write-one-to-clear of a status flag can land in the same cycle as that flag's raising condition. The bench provokes this by clearing the transmit-space flag while the free count is still at or above the level, and it expects the flag to read 1 afterwards. It then fills two entries so that the free count drops below the level, repeats the clear, and expects 0. The underrun flag is checked the same way through the interrupt line: the flag is raised, enabled, and then cleared.

// File: rtl/snd_fifo_pkg.sv
// Package: shared register indices, bit positions and widths for the
// audio FIFO pair. Assumes a 32-bit register bus with word indices.
package snd_fifo_pkg;

    localparam int REG_W      = 32;
    localparam int IRQ_W      = 7;
    localparam int IRQ_RXA    = 0;
    localparam int IRQ_TXE    = 4;
    localparam int IRQ_TXU    = 6;
    localparam logic [IRQ_W-1:0] IRQ_MASK = 7'b1010001;

    localparam int CTRL_TXFL  = 0;
    localparam int CTRL_RXFL  = 1;
    localparam int TRIG_LSB   = 8;
    localparam int TRIG_W     = 7;

    localparam int TXFREE_LSB = 16;
    localparam int TXFREE_W   = 8;
    localparam int RXAVL_LSB  = 0;
    localparam int RXAVL_W    = 6;
    localparam int RXAVL_MAX  = 63;

    typedef enum logic [2:0] {
        IDX_CTRL   = 3'd0,
        IDX_ISTAT  = 3'd1,
        IDX_IEN    = 3'd2,
        IDX_LEVEL  = 3'd3,
        IDX_TXDATA = 3'd4,
        IDX_RXDATA = 3'd5,
        IDX_TXCNT  = 3'd6,
        IDX_RXCNT  = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/snd_fifo_buf.sv
// Module: synchronous circular queue.
// What it does: stores up to DEPTH words. A push to a full queue and a pop
// from an empty queue are both ignored, and a flush empties the queue and
// blocks push and pop in that cycle. The head word is output
// combinationally and is 0 when the queue is empty.
// Assumes: one clock, synchronous active-low reset.
module snd_fifo_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 128,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_ack,
    output logic          pop_ack
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign push_ack = push && !full && !flush;
    assign pop_ack  = pop && !empty && !flush;
    assign dout     = empty ? '0 : mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ack) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy tracking, with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ack) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ack) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ack, pop_ack})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R6: a push into a full queue leaves the occupancy unchanged
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    // R3: a flush leaves the queue empty on the next cycle
    a_r3_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/snd_fifo_irq.sv
// Module: sticky interrupt flags with write-one-to-clear and enables.
// What it does: a flag bit is set by its event and cleared by a 1 in the
// clear vector, and the event wins when both occur in the same cycle. The
// request is the OR of the flags gated by their enables.
// Assumes: only the positions in IRQ_MASK exist; all other bits read 0.
module snd_fifo_irq
    import snd_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_ev,
    input  logic [IRQ_W-1:0] clr_ev,
    input  logic             en_wr,
    input  logic [IRQ_W-1:0] en_val,
    output logic [IRQ_W-1:0] stat,
    output logic [IRQ_W-1:0] en,
    output logic             irq
);

    // Flag update: clear first, then the event sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= ((stat & ~clr_ev) | set_ev) & IRQ_MASK;
        end
    end

    // Enable register, loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (en_wr) begin
            en <= en_val & IRQ_MASK;
        end
    end

    // Request: any enabled flag.
    assign irq = |(stat & en);

    // R4: a cleared flag with no event in that cycle reads 0 afterwards
    a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(clr_ev & ~set_ev & IRQ_MASK)) == '0));

    // R4: an event always leaves its flag set, even against a clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(set_ev & IRQ_MASK)) == $past(set_ev & IRQ_MASK)));

    // R5: the request is never raised without an enabled bit
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en != '0));

endmodule

// File: rtl/snd_fifo_smpcnt.sv
// Module: sample counter.
// What it does: counts one per increment strobe and is loaded by software.
// A load in the same cycle as an increment takes priority.
// Assumes: wrap-around at 2**W is acceptable.
module snd_fifo_smpcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Counter register with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R11: each increment without a load advances by exactly one
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (cnt == $past(cnt) + W'(1)));

    // R11: a software load takes effect on the next cycle
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/snd_fifo_pair.sv
// Module: top of the audio FIFO pair.
// What it does: decodes the register strobes. It holds the transmit and
// receive queues, the control register, the interrupt flags and the sample
// counters, and it registers the read data.
// Assumes: reg_wr and reg_rd are never asserted together; the serializer
// side uses single-cycle push and pop strobes.
module snd_fifo_pair
    import snd_fifo_pkg::*;
#(
    parameter int TX_DEPTH = 128,
    parameter int RX_DEPTH = 64,
    parameter int CNT_W    = 32,
    parameter logic [TRIG_W-1:0] RST_TRIG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tx_pop,
    output logic [REG_W-1:0] tx_word,
    input  logic             rx_push,
    input  logic [REG_W-1:0] rx_word,
    output logic             irq
);

    localparam int TX_CW = $clog2(TX_DEPTH + 1);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);

    reg_idx_e           idx;
    logic               tx_fl, rx_fl;
    logic [TRIG_W-1:0]  trig;
    logic [TX_CW-1:0]   tx_cnt;
    logic [RX_CW-1:0]   rx_cnt;
    logic               tx_full, tx_empty, tx_pack, tx_dack;
    logic               rx_full, rx_empty, rx_pack, rx_dack;
    logic [REG_W-1:0]   rx_head;
    logic [TX_CW-1:0]   tx_free;
    logic [IRQ_W-1:0]   set_ev, clr_ev, stat, en;
    logic [CNT_W-1:0]   txs_cnt, rxs_cnt;
    logic [REG_W-1:0]   rd_mux;
    logic               wr_ctrl, wr_istat, wr_ien, wr_txd, wr_txc, wr_rxc, rd_rxd;

    assign idx      = reg_idx_e'(reg_addr);
    assign wr_ctrl  = reg_wr && (idx == IDX_CTRL);
    assign wr_istat = reg_wr && (idx == IDX_ISTAT);
    assign wr_ien   = reg_wr && (idx == IDX_IEN);
    assign wr_txd   = reg_wr && (idx == IDX_TXDATA);
    assign wr_txc   = reg_wr && (idx == IDX_TXCNT);
    assign wr_rxc   = reg_wr && (idx == IDX_RXCNT);
    assign rd_rxd   = reg_rd && (idx == IDX_RXDATA);

    // Control register: flush bits and transmit level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_fl <= 1'b0;
            rx_fl <= 1'b0;
            trig  <= RST_TRIG;
        end else if (wr_ctrl) begin
            tx_fl <= reg_wdata[CTRL_TXFL];
            rx_fl <= reg_wdata[CTRL_RXFL];
            trig  <= reg_wdata[TRIG_LSB +: TRIG_W];
        end
    end

    snd_fifo_buf #(.W(REG_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_fl),
        .push(wr_txd), .din(reg_wdata), .pop(tx_pop), .dout(tx_word),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .push_ack(tx_pack), .pop_ack(tx_dack)
    );

    snd_fifo_buf #(.W(REG_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_fl),
        .push(rx_push), .din(rx_word), .pop(rd_rxd), .dout(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .push_ack(rx_pack), .pop_ack(rx_dack)
    );

    assign tx_free = TX_CW'(TX_DEPTH) - tx_cnt;

    // Interrupt event collection and software clear vector.
    always_comb begin
        set_ev          = '0;
        set_ev[IRQ_TXE] = int'(tx_free) >= int'(trig);
        set_ev[IRQ_TXU] = tx_pop && tx_empty;
        set_ev[IRQ_RXA] = !rx_empty;
        clr_ev          = wr_istat ? reg_wdata[IRQ_W-1:0] : '0;
    end

    snd_fifo_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
        .en_wr(wr_ien), .en_val(reg_wdata[IRQ_W-1:0]),
        .stat(stat), .en(en), .irq(irq)
    );

    snd_fifo_smpcnt #(.W(CNT_W)) u_txs (
        .clk(clk), .rst_n(rst_n), .load(wr_txc),
        .load_val(CNT_W'(reg_wdata)), .inc(tx_dack), .cnt(txs_cnt)
    );

    snd_fifo_smpcnt #(.W(CNT_W)) u_rxs (
        .clk(clk), .rst_n(rst_n), .load(wr_rxc),
        .load_val(CNT_W'(reg_wdata)), .inc(rx_pack), .cnt(rxs_cnt)
    );

    // Read data selection by register index.
    always_comb begin
        rd_mux = '0;
        case (idx)
            IDX_CTRL: begin
                rd_mux[CTRL_TXFL]             = tx_fl;
                rd_mux[CTRL_RXFL]             = rx_fl;
                rd_mux[TRIG_LSB +: TRIG_W]    = trig;
            end
            IDX_ISTAT:  rd_mux[IRQ_W-1:0]     = stat;
            IDX_IEN:    rd_mux[IRQ_W-1:0]     = en;
            IDX_LEVEL: begin
                rd_mux[TXFREE_LSB +: TXFREE_W] = TXFREE_W'(tx_free);
                rd_mux[RXAVL_LSB +: RXAVL_W]   = (int'(rx_cnt) > RXAVL_MAX)
                                                 ? RXAVL_W'(RXAVL_MAX)
                                                 : RXAVL_W'(rx_cnt);
            end
            IDX_RXDATA: rd_mux = rx_head;
            IDX_TXCNT:  rd_mux = REG_W'(txs_cnt);
            IDX_RXCNT:  rd_mux = REG_W'(rxs_cnt);
            default:    rd_mux = '0;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    // R9: reading an empty receive queue returns zero
    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |=> (reg_rdata == '0));

    // R10: a push into a full receive queue is not accepted
    a_r10_rx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |-> !rx_pack);

    // R8: a pop from an empty transmit queue raises the underrun flag
    a_r8_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_empty) |=> stat[IRQ_TXU]);

    // R11: an underrun pop does not count as a delivered word
    a_r11_no_count_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_empty && !wr_txc) |=> $stable(txs_cnt));

endmodule

// File: tb/snd_fifo_pair_bench.sv
// Bench for snd_fifo_pair. Driver tasks push the expected words into queues;
// a pop or read step compares what the design delivers against the queue head.
module snd_fifo_pair_bench;
    import snd_fifo_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0;
    logic [31:0] tx_word;
    logic        rx_push = 1'b0;
    logic [31:0] rx_word = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];

    always #10 clk = ~clk;

    snd_fifo_pair u_snd_fifo_pair (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_word(tx_word), .rx_push(rx_push),
        .rx_word(rx_word), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // Driver: a transmit write, queued as expected when it should be kept.
    task automatic tx_send(input logic [31:0] d, input bit kept);
        wr(3'd4, d);
        if (kept) txq.push_back(d);
    endtask

    // Monitor step: compare the head, then pop it.
    task automatic tx_take(input string req);
        logic [31:0] exp;
        @(negedge clk);
        exp = (txq.size() > 0) ? txq.pop_front() : 32'h0;
        check(req, tx_word, exp);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic rx_send(input logic [31:0] d, input bit kept);
        @(negedge clk);
        rx_push = 1'b1; rx_word = d;
        @(negedge clk);
        rx_push = 1'b0;
        if (kept) rxq.push_back(d);
    endtask

    task automatic rx_take(input string req);
        logic [31:0] v;
        logic [31:0] exp;
        exp = (rxq.size() > 0) ? rxq.pop_front() : 32'h0;
        rd(3'd5, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(3'd3, v); check("R1 level", v, 32'h0080_0000);
        rd(3'd1, v); check("R1 istat", v, 32'h10);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3/R7 set level 127 and read it back
        wr(3'd0, 32'h7F00);
        rd(3'd0, v); check("R3 ctrl readback", v, 32'h7F00);
        // R4 clear in the same cycle as the raising condition: set wins
        wr(3'd1, 32'h10);
        rd(3'd1, v); check("R4 set wins", v, 32'h10);
        // R4 writing zero has no effect
        wr(3'd1, 32'h0);
        rd(3'd1, v); check("R4 zero write", v, 32'h10);
        // R7 free below level then clear
        tx_send(32'hA1, 1); tx_send(32'hB2, 1);
        rd(3'd3, v); check("R2 free 126", v, 32'h007E_0000);
        wr(3'd1, 32'h10);
        rd(3'd1, v); check("R7 below level", v, 32'h0);
        tx_take("R2 order first");
        rd(3'd1, v); check("R7 at level", v, 32'h10);
        // R5 enable gating
        wr(3'd2, 32'h10); check("R5 irq on", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h0);  check("R5 irq off", {31'b0, irq}, 32'h0);
        tx_take("R2 order second");
        // R8 underrun
        check("R8 empty word", tx_word, 32'h0);
        tx_take("R8 empty pop");
        rd(3'd1, v); check("R8 underrun flag", v & 32'h40, 32'h40);
        wr(3'd2, 32'h40); check("R5 underrun irq", {31'b0, irq}, 32'h1);
        wr(3'd1, 32'h40); check("R4 clear underrun", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h0);

        // R6 full transmit queue, R11 transmit counter
        wr(3'd6, 32'h0);
        wr(3'd0, 32'h0001); wr(3'd0, 32'h0000);
        for (int i = 0; i < 128; i++) tx_send(32'h100 + i, 1);
        rd(3'd3, v); check("R6 free zero", v, 32'h0);
        tx_send(32'hDEAD, 0);
        rd(3'd3, v); check("R6 still full", v, 32'h0);
        for (int i = 0; i < 128; i++) tx_take("R6 contents intact");
        rd(3'd3, v); check("R2 free 128", v, 32'h0080_0000);
        tx_take("R8 pop after drain");
        rd(3'd6, v); check("R11 tx count", v, 32'd128);

        // R9/R10 receive side, R11 receive counter
        wr(3'd7, 32'h0);
        for (int i = 0; i < 64; i++) rx_send(32'h5000 + i, 1);
        rd(3'd3, v); check("R10 saturated", v & 32'h3F, 32'd63);
        rx_send(32'hBEEF, 0);
        rd(3'd1, v); check("R9 avail flag", v & 32'h1, 32'h1);
        for (int i = 0; i < 64; i++) rx_take("R9 rx order");
        rx_take("R9 empty read");
        rd(3'd3, v); check("R9 rx empty", v & 32'h3F, 32'h0);
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R9 avail cleared", v & 32'h1, 32'h0);
        rd(3'd7, v); check("R11 rx count", v, 32'd64);

        // R3 flush both queues
        for (int i = 0; i < 3; i++) begin
            rx_send(32'h70 + i, 0);
            tx_send(32'h80 + i, 0);
        end
        wr(3'd0, 32'h0503); wr(3'd0, 32'h0500);
        rd(3'd3, v); check("R3 flushed", v, 32'h0080_0000);
        rd(3'd0, v); check("R3 level kept", v, 32'h0500);
        check("R3 tx word", tx_word, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule